// File: doc/BRIEF.md
# Receive Flow-Delay RTS Controller

This block drives the request-to-send pin of a serial receiver from the fill level of its receive FIFO. A programmable threshold (6 bits wide) is compared against the FIFO level, and the comparison forms an internal trigger. The trigger is exported as a plain status bit for software to read and never raises an interrupt.

With hardware flow control on and a threshold of 4 or more, RTS is withdrawn on the clock edge where the level reaches the threshold. It is granted again only once the level has fallen to four entries or more below the threshold. Inside that band it keeps its last state. With flow control off, or with a threshold below 4, the mechanism is idle and RTS simply mirrors a software request bit. The FIFO and the receiver live elsewhere; only the level arrives here.

Top module: `rx_flow_rts`

## Requirements
- R1: After reset `rts_n` is 0 (RTS asserted) and `flow_trig` is 0.
- R2: With `hw_fc_en`=1 and `flow_thresh`>=4, a level of `fifo_level`>=`flow_thresh` at a clock edge sets `flow_trig`=1 and `rts_n`=1 after that edge.
- R3: `flow_trig` is 1 after an edge only when R2's condition held at that edge; otherwise it is 0.
- R4: With the mechanism active, `fifo_level`+4 <= `flow_thresh` at an edge gives `rts_n`=0 after that edge.
- R5: With the mechanism active and `flow_thresh`-4 < `fifo_level` < `flow_thresh`, `rts_n` keeps its previous value.
- R6: A `flow_thresh` value of 0 to 3 disables the mechanism: `flow_trig` is 0 and `rts_n` is the inverse of `sw_rts` after the edge, whatever the level.
- R7: With `hw_fc_en`=0, `rts_n` is the inverse of `sw_rts` after each edge and `flow_trig` is 0.
- R8: A change of `flow_thresh` is evaluated against the current level at the next edge, with no other delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_level | input | LVL_W (7) | Current receive FIFO fill level |
| flow_thresh | input | THR_W (6) | Flow-delay threshold; below 4 disables |
| hw_fc_en | input | 1 | 1 selects hardware flow control |
| sw_rts | input | 1 | Software RTS request, 1 = assert |
| rts_n | output | 1 | RTS pin, active low |
| flow_trig | output | 1 | Trigger status bit, no interrupt |

## Verification
The bench uses the default widths, a 7-bit level against a 6-bit threshold, so levels above the largest threshold and thresholds at the top of their range are both reachable. Threshold values 0 to 3 and exactly 4 are driven on purpose, which puts the disable boundary and a release point at level 0 within reach. Random walks of the level across the hysteresis band exercise hold, trip and release in many orders, together with threshold changes at an unchanged level.

// File: rtl/rx_flow_rts.sv
module rx_flow_rts #(
  parameter int LVL_W = 7,
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [THR_W-1:0] flow_thresh,
  input  logic             hw_fc_en,
  input  logic             sw_rts,
  output logic             rts_n,
  output logic             flow_trig
);
  localparam int HYST  = 4;
  localparam int MIN_T = 4;
  localparam int CW    = ((LVL_W > THR_W) ? LVL_W : THR_W) + 1;

  logic [CW-1:0] lvl_x, thr_x;
  logic active, at_thr, below_rel;
  logic rts_on_q, trig_q;

  assign lvl_x     = CW'(fifo_level);
  assign thr_x     = CW'(flow_thresh);
  assign active    = hw_fc_en && (thr_x >= CW'(MIN_T));
  assign at_thr    = lvl_x >= thr_x;
  assign below_rel = (lvl_x + CW'(HYST)) <= thr_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_on_q <= 1'b1;
      trig_q   <= 1'b0;
    end else begin
      trig_q <= active && at_thr;
      if (!active)        rts_on_q <= sw_rts;
      else if (at_thr)    rts_on_q <= 1'b0;
      else if (below_rel) rts_on_q <= 1'b1;
    end
  end

  assign rts_n     = ~rts_on_q;
  assign flow_trig = trig_q;
endmodule

// File: rtl/rx_flow_rts_chk.sv
module rx_flow_rts_chk #(
  parameter int LVL_W = 7,
  parameter int THR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] fifo_level,
  input logic [THR_W-1:0] flow_thresh,
  input logic             hw_fc_en,
  input logic             sw_rts,
  input logic             rts_n,
  input logic             flow_trig
);
  logic on;
  logic [31:0] lv, th;
  assign lv = 32'(fifo_level);
  assign th = 32'(flow_thresh);
  assign on = hw_fc_en && (th >= 4);

  // R2
  trig_drops_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flow_trig |-> rts_n);
  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && lv + 4 <= th) |=> !rts_n);
  // R5
  hold_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && lv < th && lv + 4 > th) |=> $stable(rts_n));
  // R6
  disabled_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (rts_n == !$past(sw_rts)) && !flow_trig);
  // R3
  no_trig_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lv < th) |=> !flow_trig);
endmodule

bind rx_flow_rts rx_flow_rts_chk #(.LVL_W(LVL_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .flow_thresh(flow_thresh),
  .hw_fc_en(hw_fc_en), .sw_rts(sw_rts), .rts_n(rts_n), .flow_trig(flow_trig));

// File: tb/tb_rx_flow_rts.sv
module tb_rx_flow_rts;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 7;
  localparam int THR_W = 6;

  logic clk = 0, rst_n = 0;
  logic [LVL_W-1:0] fifo_level = '0;
  logic [THR_W-1:0] flow_thresh = '0;
  logic hw_fc_en = 0, sw_rts = 0;
  logic rts_n, flow_trig;
  int compared = 0, mismatched = 0;
  int seed_dummy;
  bit m_on = 1, m_trig = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_flow_rts #(.LVL_W(LVL_W), .THR_W(THR_W)) dut (.*);

  function automatic bit next_on(bit prev, int lv, int th, bit fc, bit sw);
    if (!(fc && th >= 4)) return sw;
    if (lv >= th) return 1'b0;
    if (lv + 4 <= th) return 1'b1;
    return prev;
  endfunction

  function automatic bit next_trig(int lv, int th, bit fc);
    return fc && th >= 4 && lv >= th;
  endfunction

  function automatic string tag_of(int lv, int th, bit fc);
    if (!fc) return "R7";
    if (th < 4) return "R6";
    if (lv >= th) return "R2";
    if (lv + 4 <= th) return "R4";
    return "R5";
  endfunction

  task automatic check(string tag);
    compared++;
    if (rts_n !== !m_on || flow_trig !== m_trig) begin
      mismatched++;
      $display("FAIL %s: rts_n=%b trig=%b expected rts_n=%b trig=%b", tag,
               rts_n, flow_trig, !m_on, m_trig);
    end
  endtask

  task automatic step(int lv, int th, bit fc, bit sw, string tag = "");
    string t;
    fifo_level = LVL_W'(lv); flow_thresh = THR_W'(th); hw_fc_en = fc; sw_rts = sw;
    m_on   = next_on(m_on, lv, th, fc, sw);
    m_trig = next_trig(lv, th, fc);
    t = (tag == "") ? tag_of(lv, th, fc) : tag;
    @(negedge clk);
    check(t);
  endtask

  initial begin
    seed_dummy = $urandom(32'h5eed1);
    @(negedge clk);
    // R1
    check("R1");
    @(negedge clk); rst_n = 1;
    check("R1");
    step(20, 20, 1, 0, "R2");
    step(17, 20, 1, 0, "R5");
    step(16, 20, 1, 0, "R4");
    step(19, 20, 1, 0, "R5");
    step(19, 19, 1, 0, "R8");
    step(19, 40, 1, 0, "R8");
    step(0, 4, 1, 0, "R4");
    step(4, 4, 1, 0, "R2");
    step(1, 4, 1, 0, "R5");
    step(127, 3, 1, 1, "R6");
    step(127, 3, 1, 0, "R6");
    step(127, 0, 1, 1, "R6");
    step(127, 63, 1, 1, "R2");
    step(59, 63, 1, 1, "R4");
    step(100, 10, 0, 0, "R7");
    step(100, 10, 0, 1, "R7");
    step(5, 10, 1, 0, "R3");
    for (int i = 0; i < 4000; i++) begin
      int th, lv, r;
      r  = $urandom_range(0, 15);
      th = (r == 0) ? $urandom_range(0, 3) : $urandom_range(4, 63);
      lv = (r == 1) ? $urandom_range(0, 127) : th + $urandom_range(0, 10) - 6;
      if (lv < 0) lv = 0;
      step(lv, th, $urandom_range(0, 9) != 0, $urandom_range(0, 1), "");
    end
    done = 1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: done=0 expected done=1");
    end
  end

  initial begin
    wait (done);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100001) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule